// File: doc/BRIEF.md
# Vector-Table Backdoor Interceptor

This block sits between a host and an 8-byte pair of device registers. The pair is a 32-bit data word at local offset 0 and a 32-bit command word at local offset 4. Some devices let software reach their interrupt vector table through this pair. Software writes a command word whose type field selects the table, together with an entry offset. It then moves the entry through the data word, and it polls the top bit of the command word to follow a latch-and-complete handshake.

The interceptor recognises the accesses that target the vector table and serves them from a local table port. For those accesses it imitates the polling handshake and does not touch the real device. Every other access is forwarded to the device register window. That window begins at a base offset, which is a parameter.

A host request is taken in one cycle and answered with a registered response in the next cycle. The device port and the table port both answer within the request cycle.

Top module: `mxb_intercept`

## Requirements
- R1: Reset leaves the block inactive and clears the stored command word and the captured data word. After reset, reads of either register pass through to the device. A table write triggered before any data-word write stores the value 0.
- R2: A command-word write whose bits 30:16 equal the table type value 0x0001 makes the block active and stores the whole 32-bit value. Bits 15:12 are not compared. When bit 31 is clear, the write is also forwarded to the device command register.
- R3: A command-word write whose bits 30:16 differ from 0x0001 makes the block inactive and is forwarded to the device. This holds whatever the value of bit 31.
- R4: A matching command-word write with bit 31 set writes the captured data word to the table at entry offset bits 11:0 of the written value. This write is not forwarded to the device.
- R5: Every data-word write is captured as the data for later table writes and is also forwarded to the device data register. This holds whether the block is active or inactive.
- R6: While active, a command-word read returns the stored command value with bit 31 inverted, and the device is not accessed.
- R7: While active, a data-word read returns the table entry at bits 11:0 of the stored command value, and the device is not accessed.
- R8: While inactive, a read of local offset k (0 or 4) returns the device register at the base offset plus k. The base offset defaults to 0x70.
- R9: Only aligned 4-byte accesses are valid. A valid access has size code 2 (meaning 4 bytes), and bits 1:0 of its local offset are zero. Any other access gets an error response with read data 0. It reaches neither port and changes no state.
- R10: While the table-present input is low, a data-word read in active mode returns 0, and a triggered table write is dropped. The dropped table write is still not forwarded to the device.
- R11: Every request gets exactly one response, in the cycle after the request. Write responses carry read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Local byte offset within the register pair |
| host_size | input | 2 | Access size code (log2 of the byte count) |
| host_wdata | input | 32 | Host write data |
| host_rsp_valid | output | 1 | Response strobe, one cycle after the request |
| host_rsp_err | output | 1 | Response flags an invalid access |
| host_rdata | output | 32 | Response read data |
| dev_req | output | 1 | Forwarded device access |
| dev_we | output | 1 | Forwarded access is a write |
| dev_addr | output | 8 | Device register offset |
| dev_wdata | output | 32 | Forwarded write data |
| dev_rdata | input | 32 | Device read data, valid in the same cycle |
| tbl_present | input | 1 | Vector table capability is present |
| tbl_re | output | 1 | Table read strobe |
| tbl_we | output | 1 | Table write strobe |
| tbl_addr | output | 12 | Table entry byte offset |
| tbl_wdata | output | 32 | Table write data |
| tbl_rdata | input | 32 | Table read data, valid in the same cycle |

## Verification
The bench builds the block with its default parameters. These are a device window base of 0x70, a 12-bit entry offset and a table type value of 1. The bench table model decodes entry offset bits 7:2, so its 64 entries hold distinct preset values. With the default base, the bench can check the forwarded device offsets 0x70 and 0x74 directly against its own two-register device model. The distinct table presets make it visible whether a table read took its offset from the stored command word. Because the type value is 1, a set bit 30 alone, or type 2, is a non-matching command. This brings the exact comparison on bits 30:16 within reach.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_BAD,
        ACC_DATA_RD,
        ACC_DATA_WR,
        ACC_CMD_RD,
        ACC_CMD_WR
    } acc_kind_e;

    typedef struct packed {
        logic        active;
        logic [31:0] cmd;
        logic [31:0] data;
    } win_state_t;

    typedef struct packed {
        logic        valid;
        logic        err;
        logic [31:0] rdata;
    } host_rsp_t;

endpackage

// File: rtl/mxb_decode.sv
module mxb_decode
    import mxb_pkg::*;
#(
    parameter int LOC_AW    = 3,
    parameter int SIZE_CODE = 2
) (
    input  logic              req,
    input  logic              we,
    input  logic [LOC_AW-1:0] addr,
    input  logic [1:0]        size,
    output acc_kind_e         kind
);
    localparam int ALIGN_W = SIZE_CODE;

    logic legal;

    always_comb begin
        legal = (size == 2'(SIZE_CODE)) && (addr[ALIGN_W-1:0] == '0);
        if (!req) begin
            kind = ACC_NONE;
        end else if (!legal) begin
            kind = ACC_BAD;
        end else if (addr[ALIGN_W]) begin
            kind = we ? ACC_CMD_WR : ACC_CMD_RD;
        end else begin
            kind = we ? ACC_DATA_WR : ACC_DATA_RD;
        end
    end
endmodule

// File: rtl/mxb_cmd_match.sv
module mxb_cmd_match #(
    parameter int          DATA_W   = 32,
    parameter int          TYPE_LSB = 16,
    parameter logic [14:0] TYPE_SEL = 15'h0001
) (
    input  logic [DATA_W-1:0] value,
    output logic              hit,
    output logic              go
);
    localparam int GO_BIT = DATA_W - 1;
    localparam int TYPE_W = GO_BIT - TYPE_LSB;

    logic [TYPE_W-1:0] type_fld;

    always_comb begin
        type_fld = value[GO_BIT-1:TYPE_LSB];
        hit      = (type_fld == TYPE_W'(TYPE_SEL));
        go       = value[GO_BIT];
    end
endmodule

// File: rtl/mxb_state.sv
module mxb_state
    import mxb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  acc_kind_e   kind,
    input  logic [31:0] wdata,
    input  logic        hit,
    output win_state_t  st_q
);
    win_state_t st_d;

    always_comb begin
        st_d = st_q;
        case (kind)
            ACC_CMD_WR: begin
                st_d.active = hit;
                if (hit) begin
                    st_d.cmd = wdata;
                end
            end
            ACC_DATA_WR: st_d.data = wdata;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    activate_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_CMD_WR && hit) |=> (st_q.active && st_q.cmd == $past(wdata)));
    // R3
    deactivate_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_CMD_WR && !hit) |=> !st_q.active);
    // R5
    data_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_DATA_WR) |=> (st_q.data == $past(wdata)));
    // R9
    bad_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_BAD) |=> $stable(st_q));
endmodule

// File: rtl/mxb_route.sv
module mxb_route
    import mxb_pkg::*;
#(
    parameter int               DEV_AW   = 8,
    parameter logic [DEV_AW-1:0] DEV_BASE = 8'h70,
    parameter int               OFF_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         kind,
    input  logic [31:0]       wdata,
    input  logic              hit,
    input  logic              go,
    input  win_state_t        st,
    input  logic              tbl_present,
    input  logic [31:0]       dev_rdata,
    input  logic [31:0]       tbl_rdata,
    output logic              dev_req,
    output logic              dev_we,
    output logic [DEV_AW-1:0] dev_addr,
    output logic [31:0]       dev_wdata,
    output logic              tbl_re,
    output logic              tbl_we,
    output logic [OFF_W-1:0]  tbl_addr,
    output logic [31:0]       tbl_wdata,
    output host_rsp_t         rsp_q
);
    localparam logic [DEV_AW-1:0] CMD_DEV = DEV_BASE + DEV_AW'(4);
    localparam logic [31:0]       GO_MASK = 32'h8000_0000;

    host_rsp_t rsp_d;

    always_comb begin
        dev_req   = 1'b0;
        dev_we    = 1'b0;
        dev_addr  = DEV_BASE;
        dev_wdata = wdata;
        tbl_re    = 1'b0;
        tbl_we    = 1'b0;
        tbl_addr  = st.cmd[OFF_W-1:0];
        tbl_wdata = st.data;
        rsp_d       = '0;
        rsp_d.valid = (kind != ACC_NONE);
        case (kind)
            ACC_BAD: rsp_d.err = 1'b1;
            ACC_DATA_WR: begin
                dev_req = 1'b1;
                dev_we  = 1'b1;
            end
            ACC_CMD_WR: begin
                if (hit && go) begin
                    tbl_we   = tbl_present;
                    tbl_addr = wdata[OFF_W-1:0];
                end else begin
                    dev_req  = 1'b1;
                    dev_we   = 1'b1;
                    dev_addr = CMD_DEV;
                end
            end
            ACC_CMD_RD: begin
                if (st.active) begin
                    rsp_d.rdata = st.cmd ^ GO_MASK;
                end else begin
                    dev_req     = 1'b1;
                    dev_addr    = CMD_DEV;
                    rsp_d.rdata = dev_rdata;
                end
            end
            ACC_DATA_RD: begin
                if (st.active) begin
                    if (tbl_present) begin
                        tbl_re      = 1'b1;
                        rsp_d.rdata = tbl_rdata;
                    end
                end else begin
                    dev_req     = 1'b1;
                    rsp_d.rdata = dev_rdata;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    // R4
    table_write_private_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> !dev_req);
    // R10
    table_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we || tbl_re) |-> tbl_present);
    // R9
    bad_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_BAD) |-> (!dev_req && !tbl_we && !tbl_re));
    // R6
    active_cmd_rd_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_CMD_RD && st.active) |-> !dev_req);
    // R5
    data_wr_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_DATA_WR) |-> (dev_req && dev_we && dev_addr == DEV_BASE));
endmodule

// File: rtl/mxb_intercept.sv
module mxb_intercept
    import mxb_pkg::*;
#(
    parameter int               DEV_AW   = 8,
    parameter logic [DEV_AW-1:0] DEV_BASE = 8'h70,
    parameter int               OFF_W    = 12,
    parameter logic [14:0]      TYPE_SEL = 15'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [1:0]        host_size,
    input  logic [31:0]       host_wdata,
    output logic              host_rsp_valid,
    output logic              host_rsp_err,
    output logic [31:0]       host_rdata,
    output logic              dev_req,
    output logic              dev_we,
    output logic [DEV_AW-1:0] dev_addr,
    output logic [31:0]       dev_wdata,
    input  logic [31:0]       dev_rdata,
    input  logic              tbl_present,
    output logic              tbl_re,
    output logic              tbl_we,
    output logic [OFF_W-1:0]  tbl_addr,
    output logic [31:0]       tbl_wdata,
    input  logic [31:0]       tbl_rdata
);
    localparam int LOC_AW = 3;

    acc_kind_e  kind;
    logic       hit;
    logic       go;
    win_state_t st_q;
    host_rsp_t  rsp_q;

    mxb_decode #(.LOC_AW(LOC_AW), .SIZE_CODE(2)) u_decode (
        .req  (host_req),
        .we   (host_we),
        .addr (host_addr),
        .size (host_size),
        .kind (kind)
    );

    mxb_cmd_match #(.DATA_W(32), .TYPE_LSB(16), .TYPE_SEL(TYPE_SEL)) u_match (
        .value (host_wdata),
        .hit   (hit),
        .go    (go)
    );

    mxb_state u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .wdata (host_wdata),
        .hit   (hit),
        .st_q  (st_q)
    );

    mxb_route #(.DEV_AW(DEV_AW), .DEV_BASE(DEV_BASE), .OFF_W(OFF_W)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind        (kind),
        .wdata       (host_wdata),
        .hit         (hit),
        .go          (go),
        .st          (st_q),
        .tbl_present (tbl_present),
        .dev_rdata   (dev_rdata),
        .tbl_rdata   (tbl_rdata),
        .dev_req     (dev_req),
        .dev_we      (dev_we),
        .dev_addr    (dev_addr),
        .dev_wdata   (dev_wdata),
        .tbl_re      (tbl_re),
        .tbl_we      (tbl_we),
        .tbl_addr    (tbl_addr),
        .tbl_wdata   (tbl_wdata),
        .rsp_q       (rsp_q)
    );

    assign host_rsp_valid = rsp_q.valid;
    assign host_rsp_err   = rsp_q.err;
    assign host_rdata     = rsp_q.rdata;

    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_req |=> host_rsp_valid);
    // R11
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_req |=> !host_rsp_valid);
endmodule

// File: tb/mxb_intercept_tb.sv
module mxb_intercept_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [1:0]  host_size = 2'd2;
    logic [31:0] host_wdata = '0;
    logic        host_rsp_valid, host_rsp_err;
    logic [31:0] host_rdata;
    logic        dev_req, dev_we;
    logic [7:0]  dev_addr;
    logic [31:0] dev_wdata, dev_rdata;
    logic        tbl_present = 1'b1;
    logic        tbl_re, tbl_we;
    logic [11:0] tbl_addr;
    logic [31:0] tbl_wdata, tbl_rdata;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    logic [31:0] dev_reg [2];
    logic [31:0] tbl_mem [64];
    int          dev_wr_cnt = 0;

    logic [31:0] exp_data_q[$];
    logic        exp_err_q[$];
    string       exp_tag_q[$];

    always #2 clk = ~clk;

    mxb_intercept u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_rsp_valid(host_rsp_valid), .host_rsp_err(host_rsp_err),
        .host_rdata(host_rdata),
        .dev_req(dev_req), .dev_we(dev_we), .dev_addr(dev_addr),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .tbl_present(tbl_present), .tbl_re(tbl_re), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata)
    );

    // device model: two registers at 0x70 and 0x74
    assign dev_rdata = (dev_addr == 8'h70) ? dev_reg[0] :
                       (dev_addr == 8'h74) ? dev_reg[1] : 32'hDEAD_BEEF;
    assign tbl_rdata = tbl_mem[tbl_addr[7:2]];

    initial begin
        dev_reg[0] = 32'hD0D0_0000;
        dev_reg[1] = 32'hA0A0_0001;
        for (int i = 0; i < 64; i++) tbl_mem[i] = 32'hC000_0000 | i;
    end

    always @(posedge clk) begin
        if (dev_req && dev_we) begin
            dev_wr_cnt <= dev_wr_cnt + 1;
            if (dev_addr == 8'h70) dev_reg[0] <= dev_wdata;
            else if (dev_addr == 8'h74) dev_reg[1] <= dev_wdata;
        end
        if (tbl_we) tbl_mem[tbl_addr[7:2]] <= tbl_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected responses
    always @(negedge clk) begin
        if (rst_n && host_rsp_valid) begin
            checks++;
            if (exp_data_q.size() == 0) begin
                failures++;
                $display("FAIL R11 actual=unexpected response expected=none");
            end else begin
                automatic logic [31:0] ed = exp_data_q.pop_front();
                automatic logic        ee = exp_err_q.pop_front();
                automatic string       et = exp_tag_q.pop_front();
                if (host_rdata !== ed || host_rsp_err !== ee) begin
                    failures++;
                    $display("FAIL %s actual=%h/%b expected=%h/%b",
                             et, host_rdata, host_rsp_err, ed, ee);
                end
            end
        end
    end

    task automatic access(input logic we, input logic [2:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] exp_rd,
                          input logic exp_err, input string tag);
        @(posedge clk); #1;
        host_req = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
        exp_data_q.push_back(exp_rd);
        exp_err_q.push_back(exp_err);
        exp_tag_q.push_back(tag);
        @(posedge clk); #1;
        host_req = 1'b0;
        @(negedge clk); #1;
        chk("R11 response in next cycle", 32'(exp_data_q.size()), 32'd0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] wd, input string tag);
        access(1'b1, a, 2'd2, wd, 32'h0, 1'b0, tag);
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        access(1'b0, a, 2'd2, 32'h0, e, 1'b0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int wc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle response low", 32'(host_rsp_valid), 32'd0);
        chk("R1 idle device quiet", 32'(dev_req), 32'd0);

        // R1 / R8: inactive after reset, reads pass through
        rd(3'd4, 32'hA0A0_0001, "R1 R8 cmd read passthrough");
        rd(3'd0, 32'hD0D0_0000, "R1 R8 data read passthrough");

        // R1 / R4: captured data cleared by reset
        wc = dev_wr_cnt;
        wr(3'd4, 32'h8001_0010, "R4 trigger write");
        chk("R1 table gets cleared data", tbl_mem[4], 32'h0);
        chk("R4 trigger not forwarded", 32'(dev_wr_cnt), 32'(wc));

        // R5: data write captured and forwarded
        wr(3'd0, 32'h1234_5678, "R5 data write");
        chk("R5 data forwarded", dev_reg[0], 32'h1234_5678);

        // R4: triggered table write uses captured data
        wr(3'd4, 32'h8001_0024, "R4 trigger write 2");
        chk("R4 table entry written", tbl_mem[9], 32'h1234_5678);
        chk("R4 device cmd untouched", dev_reg[1], 32'hA0A0_0001);

        // R6 / R7
        rd(3'd4, 32'h0001_0024, "R6 inverted top bit readback");
        rd(3'd0, 32'h1234_5678, "R7 table read at stored offset");

        // R2: matching, no trigger, forwarded
        wr(3'd4, 32'h0001_0008, "R2 match write");
        chk("R2 forwarded", dev_reg[1], 32'h0001_0008);
        rd(3'd4, 32'h8001_0008, "R6 readback latched");
        rd(3'd0, 32'hC000_0002, "R7 preset entry");

        // R5: data write while active is still forwarded
        wr(3'd0, 32'h5555_AAAA, "R5 data write active");
        chk("R5 forwarded while active", dev_reg[0], 32'h5555_AAAA);

        // R3: type 2 deactivates
        wr(3'd4, 32'h0002_0008, "R3 miss write");
        chk("R3 forwarded", dev_reg[1], 32'h0002_0008);
        rd(3'd4, 32'h0002_0008, "R3 R8 cmd passthrough");
        rd(3'd0, 32'h5555_AAAA, "R3 R8 data passthrough");

        // R3: top bit with wrong type still forwarded, no table write
        wr(3'd4, 32'h8002_0030, "R3 top bit miss");
        chk("R3 top bit miss forwarded", dev_reg[1], 32'h8002_0030);
        chk("R3 no table write", tbl_mem[12], 32'hC000_000C);

        // R3: high type bit makes a mismatch
        wr(3'd4, 32'h0001_0000, "R2 reactivate");
        wr(3'd4, 32'h4001_0000, "R3 high type bit");
        rd(3'd4, 32'h4001_0000, "R3 inactive after high type bit");

        // R2: byte mask bits ignored
        wr(3'd4, 32'h0001_F00C, "R2 mask bits ignored");
        rd(3'd4, 32'h8001_F00C, "R2 R6 active with mask bits");
        rd(3'd0, 32'hC000_0003, "R7 entry with mask bits");

        // R10: capability absent
        tbl_present = 1'b0;
        rd(3'd0, 32'h0, "R10 read returns zero");
        wc = dev_wr_cnt;
        wr(3'd4, 32'h8001_0014, "R10 dropped trigger");
        chk("R10 table unchanged", tbl_mem[5], 32'hC000_0005);
        chk("R10 not forwarded", 32'(dev_wr_cnt), 32'(wc));
        rd(3'd4, 32'h0001_0014, "R10 R6 still active");
        tbl_present = 1'b1;

        // R9: invalid accesses
        wc = dev_wr_cnt;
        access(1'b1, 3'd0, 2'd1, 32'hFFFF_0000, 32'h0, 1'b1, "R9 bad size write");
        access(1'b1, 3'd6, 2'd2, 32'h0002_0000, 32'h0, 1'b1, "R9 misaligned write");
        access(1'b0, 3'd1, 2'd2, 32'h0, 32'h0, 1'b1, "R9 misaligned read");
        chk("R9 nothing forwarded", 32'(dev_wr_cnt), 32'(wc));
        chk("R9 device data untouched", dev_reg[0], 32'h5555_AAAA);
        rd(3'd4, 32'h0001_0014, "R9 state unchanged");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule